// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address into a physical address through a segment table kept in memory. The logical address carries a segment number in its upper bits and an offset in its lower bits. Two configuration registers describe the table: where it starts in table memory, and how many segments it holds. A segment number at or past that count is refused at once, without any table access. Otherwise the block reads the segment's entry over a one-cycle-latency memory read port. The entry holds the segment's physical base, its length and its access rights.

The entry is then checked against the request. The offset must lie inside the segment's length. The sum of base and offset must fit the physical address width. The requested access kind must be allowed by the rights bits. A request that passes all checks returns base plus offset, formed by addition and not by joining bit fields. Any other request returns a fault code and a zero address. Requests arrive on a valid/ready handshake, and only one is handled at a time. Each one produces exactly one single-cycle response.

Top module: `seg_xlate`

## Requirements
- R1: While reset is asserted and after its release, `rsp_valid` and `mem_rd_en` are low. `req_ready` is low in reset and high once reset has been released. The table length register resets to 0, so every request before configuration faults with the illegal-segment code.
- R2: The segment number is `req_laddr[SEG_W+OFF_W-1:OFF_W]` and the offset is `req_laddr[OFF_W-1:0]`.
- R3: A segment number greater than or equal to the table length register gives fault code 1. Its response is valid in the cycle after acceptance, and it issues no table read.
- R4: A request whose segment number is in range issues exactly one table read, in the cycle after acceptance. The read address is (table base + segment number) modulo 2^TBL_AW.
- R5: A table entry holds the segment base in bits [PA_W-1:0] and the segment length in bits [PA_W+OFF_W:PA_W]. Bits [PA_W+OFF_W+3:PA_W+OFF_W+1] hold the rights {execute, write, read}.
- R6: An offset greater than or equal to the segment length gives fault code 2.
- R7: If base + offset is 2^PA_W or more, the request gives fault code 2.
- R8: The access code selects the rights bit to test: 0 tests read, 1 tests write and 2 tests execute. Code 3 is never allowed. A missing right gives fault code 3. A fault code 2 takes precedence over fault code 3.
- R9: A request with no fault returns fault code 0 and `rsp_paddr` = base + offset, three cycles after acceptance. Every faulting response carries `rsp_paddr` = 0.
- R10: `req_ready` is low from the acceptance edge until the response cycle has ended. `rsp_valid` is high for exactly one cycle per accepted request.
- R11: While `req_ready` is high, `cfg_we` loads both the table base and the table length. While a request is in flight, `cfg_we` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Load the table base and length registers |
| cfg_tbl_base | input | TBL_AW | New table base |
| cfg_tbl_len | input | SEG_W+1 | New table length, in segments |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | SEG_W+OFF_W | Logical address: segment number above offset |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | TBL_AW | Table entry address |
| mem_rd_data | input | PA_W+OFF_W+4 | Entry, valid one cycle after the strobe |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_fault | output | 2 | 0 none, 1 illegal segment, 2 out of bounds, 3 protection |
| rsp_paddr | output | PA_W | Physical address, zero on a fault |

## Verification
On every cycle, the assertions check the handshake shape: one-cycle responses, ready held low while a response is shown, and a single read strobe tied to an acceptance. They also check that an out-of-range segment is answered on the next cycle with no table read, and that faulting responses carry a zero address. The bench scenarios cover the rest. These are the arithmetic of base plus offset, the boundary cases of the length, overflow and rights checks, and the precedence between them. They also cover wrap-around of the table address and the ignoring of configuration writes while a request is in flight. The bench checks each of these against a table model it computes itself.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_SEG   = 2'd1,
    FLT_BOUND = 2'd2,
    FLT_PROT  = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } state_e;

  localparam int RIGHTS_W = 3;
  localparam int RIGHT_RD = 0;
  localparam int RIGHT_WR = 1;
  localparam int RIGHT_EX = 2;

endpackage

// File: rtl/seg_xlate_rst_sync.sv
module seg_xlate_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/seg_xlate_len_chk.sv
module seg_xlate_len_chk #(
  parameter int SEG_W = 4
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [SEG_W:0]   tbl_len,
  output logic             illegal
);

  // The length counts segments, so a length of 2^SEG_W admits every number.
  assign illegal = ({1'b0, seg} >= tbl_len);

endmodule

// File: rtl/seg_xlate_ent_chk.sv
module seg_xlate_ent_chk
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PA_W  = 16  // must be at least OFF_W
) (
  input  logic [PA_W+OFF_W+3:0] entry,
  input  logic [OFF_W-1:0]      offset,
  input  acc_e                  acc,
  output fault_e                fault,
  output logic [PA_W-1:0]       paddr
);

  localparam int LEN_LSB = PA_W;
  localparam int LEN_MSB = PA_W + OFF_W;
  localparam int RT_LSB  = PA_W + OFF_W + 1;

  logic [PA_W-1:0]     seg_base;
  logic [OFF_W:0]      seg_len;
  logic [RIGHTS_W-1:0] rights;
  logic [PA_W:0]       sum;
  logic                past_len;
  logic                carry_out;
  logic                allowed;

  assign seg_base = entry[PA_W-1:0];
  assign seg_len  = entry[LEN_MSB:LEN_LSB];
  assign rights   = entry[RT_LSB+RIGHTS_W-1:RT_LSB];

  assign sum       = {1'b0, seg_base} + (PA_W+1)'(offset);
  assign past_len  = ({1'b0, offset} >= seg_len);
  assign carry_out = sum[PA_W];

  always_comb begin
    unique case (acc)
      ACC_READ:  allowed = rights[RIGHT_RD];
      ACC_WRITE: allowed = rights[RIGHT_WR];
      ACC_EXEC:  allowed = rights[RIGHT_EX];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (past_len || carry_out) fault = FLT_BOUND;
    else if (!allowed)         fault = FLT_PROT;
    else                       fault = FLT_NONE;
  end

  assign paddr = (fault == FLT_NONE) ? sum[PA_W-1:0] : '0;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W      = 4,
  parameter int OFF_W      = 12,
  parameter int PA_W       = 16,
  parameter int TBL_AW     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [TBL_AW-1:0]       cfg_tbl_base,
  input  logic [SEG_W:0]          cfg_tbl_len,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [SEG_W+OFF_W-1:0]  req_laddr,
  input  logic [1:0]              req_acc,
  output logic                    mem_rd_en,
  output logic [TBL_AW-1:0]       mem_rd_addr,
  input  logic [PA_W+OFF_W+3:0]   mem_rd_data,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_fault,
  output logic [PA_W-1:0]         rsp_paddr
);

  localparam int LA_W = SEG_W + OFF_W;

  logic arst_n;

  seg_xlate_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (arst_n)
  );

  // Request fields
  logic [SEG_W-1:0] req_seg;
  logic [OFF_W-1:0] req_off;
  assign req_seg = req_laddr[LA_W-1:OFF_W];
  assign req_off = req_laddr[OFF_W-1:0];

  // State and registers
  state_e              state_q, state_d;
  logic                run_q;
  logic [OFF_W-1:0]    off_q;
  acc_e                acc_q;
  logic [TBL_AW-1:0]   ent_addr_q, ent_addr_d;
  fault_e              fault_q, fault_d;
  logic [PA_W-1:0]     paddr_q, paddr_d;
  logic [TBL_AW-1:0]   tbl_base_q;
  logic [SEG_W:0]      tbl_len_q;

  // Clock enables
  logic ld_req, ld_rsp, ld_cfg;
  logic accept;
  logic seg_illegal;

  fault_e          chk_fault;
  logic [PA_W-1:0] chk_paddr;

  seg_xlate_len_chk #(.SEG_W(SEG_W)) u_len_chk (
    .seg     (req_seg),
    .tbl_len (tbl_len_q),
    .illegal (seg_illegal)
  );

  seg_xlate_ent_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_ent_chk (
    .entry  (mem_rd_data),
    .offset (off_q),
    .acc    (acc_q),
    .fault  (chk_fault),
    .paddr  (chk_paddr)
  );

  assign req_ready  = run_q && (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign ent_addr_d = tbl_base_q + TBL_AW'(req_seg);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    ld_req  = 1'b0;
    ld_rsp  = 1'b0;
    fault_d = FLT_NONE;
    paddr_d = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (seg_illegal) begin
            state_d = ST_DONE;
            ld_rsp  = 1'b1;
            fault_d = FLT_SEG;
          end else begin
            state_d = ST_LOOK;
            ld_req  = 1'b1;
          end
        end
      end
      ST_LOOK: state_d = ST_WAIT;
      ST_WAIT: begin
        state_d = ST_DONE;
        ld_rsp  = 1'b1;
        fault_d = chk_fault;
        paddr_d = chk_paddr;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ld_cfg = cfg_we && req_ready;

  // Registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_IDLE;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      off_q      <= '0;
      acc_q      <= ACC_READ;
      ent_addr_q <= '0;
    end else if (ld_req) begin
      off_q      <= req_off;
      acc_q      <= acc_e'(req_acc);
      ent_addr_q <= ent_addr_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      fault_q <= FLT_NONE;
      paddr_q <= '0;
    end else if (ld_rsp) begin
      fault_q <= fault_d;
      paddr_q <= paddr_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      tbl_base_q <= '0;
      tbl_len_q  <= '0;
    end else if (ld_cfg) begin
      tbl_base_q <= cfg_tbl_base;
      tbl_len_q  <= cfg_tbl_len;
    end
  end

  // Outputs
  assign mem_rd_en   = (state_q == ST_LOOK);
  assign mem_rd_addr = ent_addr_q;
  assign rsp_valid   = (state_q == ST_DONE);
  assign rsp_fault   = fault_q;
  assign rsp_paddr   = paddr_q;

endmodule

// File: rtl/seg_xlate_sva.sv
module seg_xlate_sva #(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [SEG_W+OFF_W-1:0] req_laddr,
  input logic                   mem_rd_en,
  input logic                   rsp_valid,
  input logic [1:0]             rsp_fault,
  input logic [PA_W-1:0]        rsp_paddr,
  input logic [SEG_W:0]         tbl_len_q
);

  logic [SEG_W-1:0] seg;
  logic             take;
  assign seg  = req_laddr[SEG_W+OFF_W-1:OFF_W];
  assign take = req_valid && req_ready;

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10

  AST_NOT_READY_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R10

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R4

  AST_READ_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> $past(take)); // R4

  AST_ILLEGAL_SEG_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ({1'b0, seg} >= tbl_len_q)) |=> (rsp_valid && rsp_fault == 2'd1 && !mem_rd_en)); // R3

  AST_LEGAL_SEG_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ({1'b0, seg} < tbl_len_q)) |=> (mem_rd_en && !rsp_valid)); // R4

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0)); // R9

endmodule

bind seg_xlate seg_xlate_sva #(
  .SEG_W (SEG_W),
  .OFF_W (OFF_W),
  .PA_W  (PA_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_laddr (req_laddr),
  .mem_rd_en (mem_rd_en),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_paddr (rsp_paddr),
  .tbl_len_q (tbl_len_q)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;

  localparam int SEG_W = 4, OFF_W = 12, PA_W = 16, TBL_AW = 8;

  logic        clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cfg_we, req_valid, req_ready, mem_rd_en, rsp_valid;
  logic [7:0]  cfg_tbl_base, mem_rd_addr;
  logic [4:0]  cfg_tbl_len;
  logic [15:0] req_laddr, rsp_paddr;
  logic [1:0]  req_acc, rsp_fault;
  logic [31:0] mem_rd_data;

  seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .TBL_AW(TBL_AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl_base(cfg_tbl_base),
    .cfg_tbl_len(cfg_tbl_len), .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .req_acc(req_acc), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  // Table memory model, one cycle read latency
  logic [31:0] tbl [256];
  logic [31:0] rd_q;
  int          rd_total = 0;
  logic [7:0]  rd_last = 8'h00;
  always @(posedge clk) begin
    if (mem_rd_en) begin
      rd_q     <= tbl[mem_rd_addr];
      rd_total <= rd_total + 1;
      rd_last  <= mem_rd_addr;
    end
  end
  assign mem_rd_data = rd_q;

  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;
  logic [7:0] m_base = 8'h00;
  logic [4:0] m_len = 5'd0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ent(input logic [2:0] rights, input logic [12:0] len,
                                         input logic [15:0] base);
    return {rights, len, base};
  endfunction

  // Expected {fault, paddr} from the requirements
  function automatic logic [17:0] expect_rsp(input logic [3:0] seg, input logic [11:0] off,
                                             input logic [1:0] acc);
    logic [31:0] e;
    int          sum;
    bit          ok;
    if ({1'b0, seg} >= m_len) return {2'd1, 16'd0};
    e   = tbl[8'(m_base + 8'(seg))];
    sum = int'(e[15:0]) + int'(off);
    if ({1'b0, off} >= e[28:16] || sum > 65535) return {2'd2, 16'd0};
    case (acc)
      2'd0: ok = e[29];
      2'd1: ok = e[30];
      2'd2: ok = e[31];
      default: ok = 1'b0;
    endcase
    if (!ok) return {2'd3, 16'd0};
    return {2'd0, 16'(sum)};
  endfunction

  task automatic cfg(input logic [7:0] b, input logic [4:0] l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tbl_base = b; cfg_tbl_len = l;
    @(negedge clk);
    cfg_we = 1'b0;
    m_base = b; m_len = l;
  endtask

  task automatic xlate(input logic [3:0] seg, input logic [11:0] off, input logic [1:0] acc,
                       input string tag, input bit poke);
    logic [17:0] e;
    int          rd0, lat;
    e = expect_rsp(seg, off, acc);
    @(negedge clk);
    check({tag, " R10 ready when idle"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_laddr = {seg, off}; req_acc = acc; rd0 = rd_total;
    @(negedge clk);
    req_valid = 1'b0; lat = 1;
    check({tag, " R10 ready low after accept"}, 32'(req_ready), 32'd0);
    if (poke) begin
      cfg_we = 1'b1; cfg_tbl_base = ~m_base; cfg_tbl_len = 5'd1;
    end
    while (!rsp_valid && lat < 8) begin
      @(negedge clk);
      cfg_we = 1'b0;
      lat++;
    end
    check({tag, " R9 latency"}, 32'(lat), (e[17:16] == 2'd1) ? 32'd1 : 32'd3);
    check({tag, " fault code"}, 32'(rsp_fault), 32'(e[17:16]));
    check({tag, " R9 paddr"}, 32'(rsp_paddr), 32'(e[15:0]));
    check({tag, " R4 read count"}, 32'(rd_total - rd0), (e[17:16] == 2'd1) ? 32'd0 : 32'd1);
    if (e[17:16] != 2'd1)
      check({tag, " R4 read address"}, 32'(rd_last), 32'(8'(m_base + 8'(seg))));
    @(negedge clk);
    check({tag, " R10 single-cycle response"}, 32'(rsp_valid), 32'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC7_0A11));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_tbl_base = '0; cfg_tbl_len = '0;
    req_valid = 1'b0; req_laddr = '0; req_acc = '0;
    for (int i = 0; i < 256; i++)
      tbl[i] = mk_ent(3'($urandom), 13'($urandom % 4097), 16'($urandom));

    repeat (3) @(negedge clk);
    check("R1 ready low in reset", 32'(req_ready), 32'd0);
    check("R1 no response in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready after release", 32'(req_ready), 32'd1);
    check("R1 no read after release", 32'(mem_rd_en), 32'd0);
    check("R1 no response after release", 32'(rsp_valid), 32'd0);
    xlate(4'd0, 12'h000, 2'd0, "R1 unconfigured length", 1'b0);

    // Directed table at 0x40, ten segments
    tbl[8'h40] = mk_ent(3'b001, 13'h0100, 16'h1000);
    tbl[8'h41] = mk_ent(3'b111, 13'h1000, 16'h2000);
    tbl[8'h43] = mk_ent(3'b100, 13'h0200, 16'h3000);
    tbl[8'h44] = mk_ent(3'b111, 13'h1000, 16'hF000);
    tbl[8'h45] = mk_ent(3'b111, 13'h1000, 16'hF001);
    tbl[8'h46] = mk_ent(3'b000, 13'h0010, 16'h0500);
    tbl[8'h47] = mk_ent(3'b111, 13'h0000, 16'h0700);
    tbl[8'h49] = mk_ent(3'b011, 13'h0800, 16'h9000);
    cfg(8'h40, 5'd10);  // R11

    xlate(4'd1, 12'h123, 2'd0, "R2 R5 field split", 1'b0);
    xlate(4'd9, 12'h7FF, 2'd1, "R3 last legal segment", 1'b0);
    xlate(4'd10, 12'h000, 2'd0, "R3 segment equal to length", 1'b0);
    xlate(4'd15, 12'hABC, 2'd2, "R3 top segment", 1'b0);
    xlate(4'd0, 12'h0FF, 2'd0, "R6 offset below length", 1'b0);
    xlate(4'd0, 12'h100, 2'd0, "R6 offset equal to length", 1'b0);
    xlate(4'd7, 12'h000, 2'd0, "R6 zero-length segment", 1'b0);
    xlate(4'd1, 12'hFFF, 2'd0, "R6 full-size segment", 1'b0);
    xlate(4'd4, 12'hFFF, 2'd2, "R7 sum at top", 1'b0);
    xlate(4'd5, 12'hFFF, 2'd0, "R7 sum overflows", 1'b0);
    xlate(4'd5, 12'hFFE, 2'd0, "R7 sum just fits", 1'b0);
    xlate(4'd0, 12'h010, 2'd1, "R8 write to read-only", 1'b0);
    xlate(4'd0, 12'h010, 2'd2, "R8 execute read-only", 1'b0);
    xlate(4'd3, 12'h010, 2'd2, "R8 execute allowed", 1'b0);
    xlate(4'd3, 12'h010, 2'd0, "R8 read execute-only", 1'b0);
    xlate(4'd1, 12'h010, 2'd3, "R8 reserved access", 1'b0);
    xlate(4'd6, 12'h020, 2'd0, "R8 bound over rights", 1'b0);
    xlate(4'd6, 12'h000, 2'd0, "R8 no rights", 1'b0);

    // Configuration write while busy is dropped
    xlate(4'd1, 12'h040, 2'd1, "R11 write during request", 1'b1);
    xlate(4'd9, 12'h001, 2'd0, "R11 length kept", 1'b0);

    // Table address wraps
    tbl[8'h01] = mk_ent(3'b111, 13'h0400, 16'h4400);
    cfg(8'hFC, 5'd8);
    xlate(4'd5, 12'h3FF, 2'd1, "R4 table address wrap", 1'b0);
    cfg(8'h20, 5'd16);
    xlate(4'd15, 12'h001, 2'd0, "R3 full-length table", 1'b0);

    // Random traffic
    for (int n = 0; n < 300; n++) begin
      logic [3:0]  s;
      logic [11:0] o;
      logic [12:0] l;
      if (n % 50 == 0) cfg(8'($urandom), 5'($urandom % 17));
      s = 4'($urandom);
      l = tbl[8'(m_base + 8'(s))][28:16];
      if ($urandom % 2 == 0) o = 12'(l - 13'd1 + 13'($urandom % 3));
      else                   o = 12'($urandom);
      xlate(s, o, 2'($urandom), "R2 R5 R9 random", 1'b0);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule